// File: doc/BRIEF.md
# GPIO Port with Interrupt Triggers

This block is a word-addressed general-purpose I/O port. Software sets each pin as an input or an output through a direction register. It drives output levels through a data register, and reading that same register returns the synchronised level of every pin. A control register lets the four lowest pins act as external interrupt inputs. Each of those lines has its own enable bit and a 3-bit trigger code, and the code selects active-low level, active-high level, rising edge, falling edge or both edges. The same control register lets two further pins carry the outputs of two timers that sit outside the block.

Every pin input passes through a two-flop synchroniser before anything reads it. Edge detection compares the synchronised value with the value it held one clock earlier, so an edge-mode interrupt is a pulse one clock long. A level-mode interrupt follows the synchronised pin for as long as the line is enabled. The timers, the interrupt controller and the bus bridge are outside this block.

Top module: `gpio_irq_port`

## Requirements
- R1: The direction register is at byte address 0x00, the control register at 0x04 and the data register at 0x08. A write or read at any other address, including one with nonzero address bits [1:0], changes nothing and reads 0.
- R2: Direction bit i controls pin i. A 1 makes the pin an output (pin_oe[i]=1) driven from data register bit i. A 0 makes it an input. After reset every pin is an input.
- R3: A read at 0x08 returns bit i equal to pin_in[i] as it was two rising clock edges earlier (two-flop synchroniser). A write at 0x08 sets the output levels on pin_out.
- R4: For interrupt line n (0 to 3), control bits [4n+2:4n] hold the trigger code and bit 4n+3 is the enable. While line n is enabled, pin n is forced to be an input whatever its direction bit says. A read at 0x04 returns the control bits written, bits [17:0].
- R5: Control bit 16 gives pin 4 to timer 0: pin_oe[4]=1 and pin_out[4]=tmr_in[0]. Control bit 17 does the same for pin 5 with tmr_in[1].
- R6: With trigger code 0 (active-low level) and the line enabled, irq[n] is the inverse of the synchronised pin n.
- R7: With trigger code 1 (active-high level) and the line enabled, irq[n] equals the synchronised pin n.
- R8: When bit 1 of the code is set (codes 2, 3, 6, 7), a 0-to-1 change of the synchronised pin raises irq[n] for exactly one clock.
- R9: When bit 2 of the code is set (codes 4, 5, 6, 7), a 1-to-0 change of the synchronised pin raises irq[n] for one clock. Code 6 and code 7 react to both edges.
- R10: While the enable bit of line n is clear, irq[n] stays low. After reset all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Pad output levels |
| pin_oe | output | NUM_PINS | Pad output enables |
| tmr_in | input | 2 | Outputs of timer 0 and timer 1 |
| irq | output | 4 | Interrupt request per line |

## Verification
The bench builds the port with NUM_PINS=8. Pins 6 and 7 then have no special role, so the direction and data paths are checked on plain pins as well as on the interrupt and timer pins. It runs the default two-stage synchroniser, so the latency can be checked against the exact two-edge delay. The trigger codes are loaded in two sets covering all eight values, plus a set with every line disabled. A pseudo-random pin pattern then produces both single-cycle edges and long levels on every line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Interrupt lines and control register layout
    localparam int IRQ_LINES   = 4;
    localparam int CTRL_W      = 18;
    localparam int TMR_EN_LSB  = 16;

    // Word indices of the three registers
    localparam int WIDX_DIR    = 0;
    localparam int WIDX_CTRL   = 1;
    localparam int WIDX_DATA   = 2;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_CTRL,
        SEL_DATA
    } reg_sel_t;

    typedef struct packed {
        logic       en;
        logic [2:0] code;
    } trig_cfg_t;

    typedef struct packed {
        logic is_level;
        logic hi_active;
        logic on_rise;
        logic on_fall;
    } trig_dec_t;

    function automatic trig_dec_t decode_trig(input logic [2:0] code);
        trig_dec_t d;
        d.is_level  = (code[2:1] == 2'b00);
        d.hi_active = code[0];
        d.on_rise   = code[1];
        d.on_fall   = code[2];
        return d;
    endfunction

    function automatic reg_sel_t pick_reg(input logic aligned, input int unsigned widx);
        if (!aligned)                return SEL_NONE;
        else if (widx == WIDX_DIR)   return SEL_DIR;
        else if (widx == WIDX_CTRL)  return SEL_CTRL;
        else if (widx == WIDX_DATA)  return SEL_DATA;
        else                         return SEL_NONE;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
            prev_q <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
            prev_q <= stg[STAGES-1];
        end
    end

    assign sync_q = stg[STAGES-1];

    // R3: the delayed copy trails the synchronised value by one clock
    p_prev_trails_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> prev_q == $past(sync_q));
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trig_cfg_t cfg,
    input  logic      cur,
    input  logic      old,
    output logic      irq
);
    trig_dec_t dec;
    logic      level_hit;
    logic      edge_hit;

    always_comb begin
        dec       = decode_trig(cfg.code);
        level_hit = dec.hi_active ? cur : ~cur;
        edge_hit  = (dec.on_rise & cur & ~old) | (dec.on_fall & ~cur & old);
        irq       = cfg.en & (dec.is_level ? level_hit : edge_hit);
    end

    // R8: a rise-only trigger never holds its request for two clocks
    p_rise_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && cfg.code == 3'd2 && irq) ##1 $stable(cfg) |-> !irq);

    // R9: a fall-only trigger never holds its request for two clocks
    p_fall_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && cfg.code == 3'd4 && irq) ##1 $stable(cfg) |-> !irq);
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int TMR0_PIN = 4,
    parameter int TMR1_PIN = 5
) (
    input  logic [NUM_PINS-1:0]  dir_q,
    input  logic [NUM_PINS-1:0]  data_q,
    input  logic [IRQ_LINES-1:0] int_en,
    input  logic [1:0]           tmr_en,
    input  logic [1:0]           tmr_in,
    output logic [NUM_PINS-1:0]  pin_out,
    output logic [NUM_PINS-1:0]  pin_oe
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        if (i < IRQ_LINES) begin : g_irq_pin
            assign pin_oe[i]  = int_en[i] ? 1'b0 : dir_q[i];
            assign pin_out[i] = data_q[i];
        end else if (i == TMR0_PIN) begin : g_tmr0_pin
            assign pin_oe[i]  = tmr_en[0] | dir_q[i];
            assign pin_out[i] = tmr_en[0] ? tmr_in[0] : data_q[i];
        end else if (i == TMR1_PIN) begin : g_tmr1_pin
            assign pin_oe[i]  = tmr_en[1] | dir_q[i];
            assign pin_out[i] = tmr_en[1] ? tmr_in[1] : data_q[i];
        end else begin : g_plain_pin
            assign pin_oe[i]  = dir_q[i];
            assign pin_out[i] = data_q[i];
        end
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS    = 16,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int TMR0_PIN    = 4,
    parameter int TMR1_PIN    = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_PINS-1:0]  pin_in,
    output logic [NUM_PINS-1:0]  pin_out,
    output logic [NUM_PINS-1:0]  pin_oe,
    input  logic [1:0]           tmr_in,
    output logic [IRQ_LINES-1:0] irq
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] data_q;
    logic [CTRL_W-1:0]   ctrl_q;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pin_prev;
    logic [IRQ_LINES-1:0] int_en;
    reg_sel_t            sel;
    logic                unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata;

    assign sel = pick_reg(bus_addr[1:0] == 2'b00,
                          32'(bus_addr[ADDR_W-1:ADDR_W-WIDX_W]));

    // Register file
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            data_q <= '0;
            ctrl_q <= '0;
        end else if (bus_we) begin
            case (sel)
                SEL_DIR:  dir_q  <= bus_wdata[NUM_PINS-1:0];
                SEL_CTRL: ctrl_q <= bus_wdata[CTRL_W-1:0];
                SEL_DATA: data_q <= bus_wdata[NUM_PINS-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DIR:  bus_rdata[NUM_PINS-1:0] = dir_q;
            SEL_CTRL: bus_rdata[CTRL_W-1:0]   = ctrl_q;
            SEL_DATA: bus_rdata[NUM_PINS-1:0] = pin_sync;
            default:  ;
        endcase
    end

    gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d      (pin_in),
        .sync_q (pin_sync),
        .prev_q (pin_prev)
    );

    for (genvar n = 0; n < IRQ_LINES; n++) begin : g_line
        trig_cfg_t cfg;
        assign cfg.en   = ctrl_q[4*n+3];
        assign cfg.code = ctrl_q[4*n+2 -: 3];
        assign int_en[n] = cfg.en;

        gpio_trig_detect u_det (
            .clk (clk),
            .rst (rst),
            .cfg (cfg),
            .cur (pin_sync[n]),
            .old (pin_prev[n]),
            .irq (irq[n])
        );

        // R10: a disabled line never requests
        p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
            !ctrl_q[4*n+3] |-> !irq[n]);

        // R4: an enabled interrupt line keeps its pin as input
        p_irq_pin_input_r4: assert property (@(posedge clk) disable iff (rst)
            ctrl_q[4*n+3] |-> !pin_oe[n]);

        // R7: active-high level follows the synchronised pin
        p_level_high_r7: assert property (@(posedge clk) disable iff (rst)
            (ctrl_q[4*n+3 -: 4] == 4'b1001) |-> irq[n] == pin_sync[n]);
    end

    gpio_pin_mux #(
        .NUM_PINS (NUM_PINS),
        .TMR0_PIN (TMR0_PIN),
        .TMR1_PIN (TMR1_PIN)
    ) u_mux (
        .dir_q   (dir_q),
        .data_q  (data_q),
        .int_en  (int_en),
        .tmr_en  (ctrl_q[TMR_EN_LSB+1:TMR_EN_LSB]),
        .tmr_in  (tmr_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // R5: a granted timer pin drives the timer level
    p_timer0_drive_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[TMR_EN_LSB] |-> (pin_oe[TMR0_PIN] && pin_out[TMR0_PIN] == tmr_in[0]));
    p_timer1_drive_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[TMR_EN_LSB+1] |-> (pin_oe[TMR1_PIN] && pin_out[TMR1_PIN] == tmr_in[1]));

    // R1: a write away from the direction register leaves it alone
    p_dir_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && sel == SEL_DIR) |=> $stable(dir_q));
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [1:0]    tmr_in = '0;
    logic [3:0]    irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Reference state
    logic [NP-1:0] m_dir = '0, m_data = '0;
    logic [17:0]   m_ctrl = '0;
    logic [NP-1:0] hist[$] = '{'0, '0, '0};

    always #4 clk = ~clk;

    gpio_irq_port #(.NUM_PINS(NP), .ADDR_W(4)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .tmr_in(tmr_in), .irq(irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_dir = '0; m_data = '0; m_ctrl = '0;
            hist = '{'0, '0, '0};
        end else begin
            if (bus_we && bus_addr[1:0] == 2'b00) begin
                case (bus_addr[3:2])
                    2'd0: m_dir  = bus_wdata[NP-1:0];
                    2'd1: m_ctrl = bus_wdata[17:0];
                    2'd2: m_data = bus_wdata[NP-1:0];
                    default: ;
                endcase
            end
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    function automatic logic exp_irq(int n);
        int  code = int'(m_ctrl[4*n +: 3]);
        logic s = hist[1][n];
        logic p = hist[2][n];
        if (!m_ctrl[4*n+3]) return 1'b0;
        if (code == 0) return !s;
        if (code == 1) return s;
        return ((code & 2) != 0 && s && !p) || ((code & 4) != 0 && !s && p);
    endfunction

    function automatic logic [31:0] exp_rdata();
        if (bus_addr[1:0] != 2'b00) return 32'd0;
        case (bus_addr[3:2])
            2'd0: return 32'(m_dir);
            2'd1: return 32'(m_ctrl);
            2'd2: return 32'(hist[1]);
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
        end
    endtask

    // Compare outputs with the model on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            logic [NP-1:0] eo, ev;
            logic [3:0] ei;
            for (int i = 0; i < NP; i++) begin
                if (i < 4) begin
                    eo[i] = m_ctrl[4*i+3] ? 1'b0 : m_dir[i];
                    ev[i] = m_data[i];
                end else if (i == 4 || i == 5) begin
                    eo[i] = m_ctrl[12+i] | m_dir[i];
                    ev[i] = m_ctrl[12+i] ? tmr_in[i-4] : m_data[i];
                end else begin
                    eo[i] = m_dir[i];
                    ev[i] = m_data[i];
                end
            end
            for (int n = 0; n < 4; n++) ei[n] = exp_irq(n);
            check("R1/R3 read data", bus_rdata, exp_rdata());
            check("R2/R4/R5 output enables", 32'(pin_oe), 32'(eo));
            check("R2/R3/R5 output levels", 32'(pin_out), 32'(ev));
            check("R6/R7/R8/R9/R10 irq", 32'(irq), 32'(ei));
        end
    end

    task automatic step(logic we, logic [3:0] a, logic [31:0] d, logic rnd);
        @(negedge clk);
        #1;
        bus_we = we; bus_addr = a; bus_wdata = d;
        if (rnd) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pin_in = lfsr[NP-1:0] ^ {NP{lfsr[15]}};
            tmr_in = lfsr[9:8];
        end
    endtask

    task automatic run(int n, logic [31:0] d);
        for (int k = 0; k < n; k++) step(1'b0, 4'(4 * (k % 4)), d, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: every register reads zero after reset
        for (int a = 0; a < 3; a++) begin
            step(1'b0, 4'(4 * a), '0, 1'b0);
            #1;
            check("R10 reset read", bus_rdata, 32'd0);
        end
        check("R10 reset irq", 32'(irq), 32'd0);
        // R1: unaligned and unused addresses
        step(1'b1, 4'h1, 32'hFF, 1'b0);
        step(1'b1, 4'hC, 32'hFF, 1'b0);
        step(1'b0, 4'h0, '0, 1'b0);
        #1;
        check("R1 stray writes ignored", bus_rdata, 32'd0);
        // R2/R3: direction and data on plain pins
        step(1'b1, 4'h0, 32'hC3, 1'b0);
        step(1'b1, 4'h8, 32'hA5, 1'b0);
        run(24, 32'h0);
        // R6/R7/R8/R9: codes 0,1,2,4
        step(1'b1, 4'h4, 32'h0000_CA98, 1'b0);
        run(60, 32'h0);
        // R9/R5: codes 6,3,5,7 plus both timers
        step(1'b1, 4'h4, 32'h0003_FDBE, 1'b0);
        step(1'b1, 4'h0, 32'hFF, 1'b0);
        run(60, 32'h0);
        // R10: codes set but no enables
        step(1'b1, 4'h4, 32'h0000_7771, 1'b0);
        run(30, 32'h0);
        step(1'b0, 4'h4, '0, 1'b0);
        #1;
        check("R4 control read back", bus_rdata, 32'h7771);
        step(1'b0, 4'hC, '0, 1'b1);
        #1;
        check("R1 unused address reads zero", bus_rdata, 32'd0);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule